// File: doc/BRIEF.md
# Clock Source Switch Controller

This controller decides which oscillator clocks a small microcontroller core. It switches between an internal RC path and a primary crystal or PLL path. The internal path has two members. The slow RC oscillator runs always and clocks this controller. The fast internal oscillator is enabled through a frequency field and a force bit. The controller drives the select input of an external glitch-free clock multiplexer. It also drives enables for the fast internal, primary and slow RC oscillators, and two status flags. The first flag reports that the fast internal oscillator is stable. The second reports that primary start-up has completed.

A request for the primary source does not stop the core. The multiplexer stays on the current internal source while a counter waits for a number of rising edges on the primary oscillator. If the PLL is in use, the controller then also waits for a lock interval, timed on the RC clock, and for the lock indication. Only when all of these conditions hold does the select move to the primary source. Stable, lock and tick inputs come from other clock domains and pass through two-flop synchronizers. The controller only reads the configuration bits and never writes them back.

Top module: `clkSrcSwitch`

## Requirements
- R1: Reset state: `clkSel` reads 2'b00, which selects the slow RC. `intStable` and `startupDone` are 0. `rcEn` is 1. With `sysClkSel` not equal to 2'b00 and `freqSel` zero, `priOscEn` and `fastOscEn` are 0.
- R2: While `freqSel` is zero and `intSrcSel` is 0, `fastOscEn` and `intStable` stay 0 and `clkSel` stays 2'b00, whatever `fastStable` does.
- R3: While the internal path is active and `freqSel` is nonzero or `intSrcSel` is 1, `fastOscEn` is 1. `clkSel` stays 2'b00 and `intStable` stays 0 until `fastStable` is seen high. Within 6 cycles after that, `intStable` is 1 and `clkSel` is 2'b01.
- R4: If `intStable` is already 1, it stays 1 and `clkSel` stays 2'b01 while a primary switch is pending or after one is abandoned.
- R5: `sysClkSel` equal to 2'b00 requests the primary source and raises `priOscEn`. Any other value selects the internal path. Before `OST_TICKS` rising edges of `priTick` have arrived after the request, `clkSel` does not change.
- R6: When `usePll` is 1, the switch also needs `PLL_WAIT` RC cycles after the edge count ends and `pllLock` seen high. The later of the two sets the switch time.
- R7: When the switch completes, `clkSel` is 2'b10, `startupDone` is 1, and `intStable` and `fastOscEn` are 0.
- R8: `rcEn` is 1 while the internal path is active, while a switch is pending, or while `wdtEn` or `fscmEn` is 1. On the primary source with both enables at 0, `rcEn` is 0.
- R9: If the request is withdrawn or `usePll` changes while a switch is pending, the pending sequence is abandoned. The edge count restarts from zero and the active source does not change.
- R10: A request for the internal path while on primary takes effect within 6 cycles. `startupDone` and `priOscEn` drop, and `clkSel` returns to the internal choice of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow RC clock |
| rstN | input | 1 | Active-low reset |
| freqSel | input | FREQ_W | Fast internal oscillator frequency field; zero disables it |
| intSrcSel | input | 1 | Forces the fast internal oscillator on |
| sysClkSel | input | 2 | 2'b00 requests primary; other values request the internal path |
| usePll | input | 1 | Primary path goes through the PLL |
| priTick | input | 1 | Primary oscillator divided tick (asynchronous) |
| fastStable | input | 1 | Fast internal oscillator stable (asynchronous) |
| pllLock | input | 1 | PLL lock indication (asynchronous) |
| wdtEn | input | 1 | Watchdog enabled |
| fscmEn | input | 1 | Fail-safe clock monitor enabled |
| clkSel | output | 2 | Multiplexer select: 00 slow RC, 01 fast internal, 10 primary |
| fastOscEn | output | 1 | Fast internal oscillator enable |
| priOscEn | output | 1 | Primary oscillator enable |
| rcEn | output | 1 | Slow RC oscillator keep-running enable |
| intStable | output | 1 | Fast internal oscillator stable flag |
| startupDone | output | 1 | Primary start-up complete flag |

## Verification
The bench sweeps every frequency field value and force bit, with and without the PLL. It checks three things. The multiplexer must stay on the slow RC until the fast oscillator is stable, or a premature select appears. The switch must wait for exactly the edge count, one edge short and then one more, so an off-by-one count shows up. It must also wait for lock as well as the timer, or it switches to an unlocked PLL. Abandoned and restarted requests expose a counter that is not cleared, because the switch then comes early. A stable flag that drops during a pending switch would show a false low. All four enable combinations for the keep-running RC are checked on the primary source.

// File: rtl/clkSwPkg.sv
package clkSwPkg;
  typedef enum logic [1:0] {
    SRC_SLOW = 2'b00,
    SRC_FAST = 2'b01,
    SRC_PRI  = 2'b10
  } clkSrcE;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_OST  = 2'b01,
    ST_PLL  = 2'b10
  } swStateE;

  typedef struct packed {
    logic clrCnt;
    logic runOst;
    logic runPll;
    logic commitPri;
    logic commitInt;
  } swStrobeS;
endpackage

// File: rtl/clkSwSync.sv
module clkSwSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= asyncIn;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/clkSwCtrl.sv
module clkSwCtrl
  import clkSwPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     targetPri,
  input  logic     usePll,
  input  logic     activePri,
  input  logic     ostDone,
  input  logic     pllReady,
  output swStrobeS strobe,
  output logic     pending
);
  swStateE state, stateNext;
  logic    pllMode;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (targetPri && !activePri) begin
          strobe.clrCnt = 1'b1;
          stateNext     = ST_OST;
        end else if (!targetPri && activePri) begin
          strobe.commitInt = 1'b1;
        end
      end
      ST_OST: begin
        strobe.runOst = 1'b1;
        if (!targetPri) begin
          strobe.clrCnt = 1'b1;
          stateNext     = ST_IDLE;
        end else if (usePll != pllMode) begin
          strobe.clrCnt = 1'b1;
        end else if (ostDone) begin
          if (pllMode) begin
            stateNext = ST_PLL;
          end else begin
            strobe.commitPri = 1'b1;
            stateNext        = ST_IDLE;
          end
        end
      end
      ST_PLL: begin
        strobe.runPll = 1'b1;
        if (!targetPri) begin
          strobe.clrCnt = 1'b1;
          stateNext     = ST_IDLE;
        end else if (usePll != pllMode) begin
          strobe.clrCnt = 1'b1;
          stateNext     = ST_OST;
        end else if (pllReady) begin
          strobe.commitPri = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pllMode <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.clrCnt) pllMode <= usePll;
    end
  end

  assign pending = (state != ST_IDLE);
endmodule

// File: rtl/clkSwDatapath.sv
module clkSwDatapath
  import clkSwPkg::*;
#(
  parameter int FREQ_W    = 3,
  parameter int OST_TICKS = 1024,
  parameter int PLL_WAIT  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  swStrobeS          strobe,
  input  logic [FREQ_W-1:0] freqSel,
  input  logic              intSrcSel,
  input  logic              priTickS,
  input  logic              fastStableS,
  input  logic              pllLockS,
  output logic              activePri,
  output logic              ostDone,
  output logic              pllReady,
  output logic              intStable,
  output logic              startupDone,
  output logic              fastOscEn,
  output logic [1:0]        clkSel
);
  localparam int OST_W = $clog2(OST_TICKS + 1);
  localparam int PLL_W = $clog2(PLL_WAIT + 1);

  logic             tickPrev, tickRise, fastWanted, pllTimerDone;
  logic [OST_W-1:0] ostCnt;
  logic [PLL_W-1:0] pllCnt;
  clkSrcE           srcSel;

  assign fastWanted   = (|freqSel) || intSrcSel;
  assign tickRise     = priTickS && !tickPrev;
  assign ostDone      = (ostCnt == OST_W'(OST_TICKS));
  assign pllTimerDone = (pllCnt == PLL_W'(PLL_WAIT));
  assign pllReady     = pllTimerDone && pllLockS;
  assign fastOscEn    = fastWanted && !activePri;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickPrev <= 1'b0;
      ostCnt   <= '0;
      pllCnt   <= '0;
    end else begin
      tickPrev <= priTickS;
      if (strobe.clrCnt) begin
        ostCnt <= '0;
        pllCnt <= '0;
      end else begin
        if (strobe.runOst && tickRise && !ostDone) ostCnt <= ostCnt + 1'b1;
        if (strobe.runPll && !pllTimerDone)        pllCnt <= pllCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePri   <= 1'b0;
      startupDone <= 1'b0;
      intStable   <= 1'b0;
    end else begin
      if (strobe.commitPri) begin
        activePri   <= 1'b1;
        startupDone <= 1'b1;
      end else if (strobe.commitInt) begin
        activePri   <= 1'b0;
        startupDone <= 1'b0;
      end
      intStable <= fastWanted && fastStableS && !activePri && !strobe.commitPri;
    end
  end

  always_comb begin
    if (activePri)                    srcSel = SRC_PRI;
    else if (intStable && fastWanted) srcSel = SRC_FAST;
    else                              srcSel = SRC_SLOW;
  end

  assign clkSel = srcSel;
endmodule

// File: rtl/clkSrcSwitch.sv
module clkSrcSwitch
  import clkSwPkg::*;
#(
  parameter int FREQ_W      = 3,
  parameter int OST_TICKS   = 1024,
  parameter int PLL_WAIT    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FREQ_W-1:0] freqSel,
  input  logic              intSrcSel,
  input  logic [1:0]        sysClkSel,
  input  logic              usePll,
  input  logic              priTick,
  input  logic              fastStable,
  input  logic              pllLock,
  input  logic              wdtEn,
  input  logic              fscmEn,
  output logic [1:0]        clkSel,
  output logic              fastOscEn,
  output logic              priOscEn,
  output logic              rcEn,
  output logic              intStable,
  output logic              startupDone
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] rawIn, syncIn;
  logic              targetPri, activePri, ostDone, pllReady, pending;
  swStrobeS          strobe;

  assign rawIn     = {pllLock, fastStable, priTick};
  assign targetPri = (sysClkSel == 2'b00);

  clkSwSync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  clkSwCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .targetPri(targetPri), .usePll(usePll),
    .activePri(activePri), .ostDone(ostDone), .pllReady(pllReady),
    .strobe(strobe), .pending(pending)
  );

  clkSwDatapath #(.FREQ_W(FREQ_W), .OST_TICKS(OST_TICKS), .PLL_WAIT(PLL_WAIT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .freqSel(freqSel),
    .intSrcSel(intSrcSel), .priTickS(syncIn[0]), .fastStableS(syncIn[1]),
    .pllLockS(syncIn[2]), .activePri(activePri), .ostDone(ostDone),
    .pllReady(pllReady), .intStable(intStable), .startupDone(startupDone),
    .fastOscEn(fastOscEn), .clkSel(clkSel)
  );

  assign priOscEn = targetPri || activePri;
  assign rcEn     = !activePri || pending || wdtEn || fscmEn;
endmodule

// File: rtl/clkSwChk.sv
module clkSwChk (
  input logic       clk,
  input logic       rstN,
  input logic       wdtEn,
  input logic       fscmEn,
  input logic [1:0] clkSel,
  input logic       fastOscEn,
  input logic       priOscEn,
  input logic       rcEn,
  input logic       intStable,
  input logic       startupDone
);
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    clkSel != 2'b11); // R1

  AST_STABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    intStable |-> $past(fastOscEn)); // R3

  AST_PRI_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startupDone) |-> $past(priOscEn)); // R5

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(intStable && startupDone)); // R7

  AST_RC_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (wdtEn || fscmEn) |-> rcEn); // R8

  AST_DONE_HOLDS_PRI: assert property (@(posedge clk) disable iff (!rstN)
    startupDone |-> priOscEn); // R10
endmodule

bind clkSrcSwitch clkSwChk chk_i (
  .clk(clk), .rstN(rstN), .wdtEn(wdtEn), .fscmEn(fscmEn), .clkSel(clkSel),
  .fastOscEn(fastOscEn), .priOscEn(priOscEn), .rcEn(rcEn),
  .intStable(intStable), .startupDone(startupDone)
);

// File: tb/clkSrcSwitch_tb_top.sv
`timescale 1ns/1ps
module clkSrcSwitch_tb_top;
  localparam int FREQ_W = 3;
  localparam int OST    = 16;
  localparam int PWAIT  = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [FREQ_W-1:0] freqSel = '0;
  logic              intSrcSel = 1'b0;
  logic [1:0]        sysClkSel = 2'b10;
  logic              usePll = 1'b0, priTick = 1'b0, fastStable = 1'b0, pllLock = 1'b0;
  logic              wdtEn = 1'b0, fscmEn = 1'b0;
  logic [1:0]        clkSel;
  logic              fastOscEn, priOscEn, rcEn, intStable, startupDone;

  int  nRun = 0, nFail = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  clkSrcSwitch #(.FREQ_W(FREQ_W), .OST_TICKS(OST), .PLL_WAIT(PWAIT)) dut_i (
    .clk(clk), .rstN(rstN), .freqSel(freqSel), .intSrcSel(intSrcSel),
    .sysClkSel(sysClkSel), .usePll(usePll), .priTick(priTick),
    .fastStable(fastStable), .pllLock(pllLock), .wdtEn(wdtEn), .fscmEn(fscmEn),
    .clkSel(clkSel), .fastOscEn(fastOscEn), .priOscEn(priOscEn), .rcEn(rcEn),
    .intStable(intStable), .startupDone(startupDone)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      priTick = 1'b1; step(2);
      priTick = 1'b0; step(2);
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nRun++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    step(3);
    // R1 reset values
    chk("R1", "clkSel in reset", clkSel, 0);
    chk("R1", "intStable", intStable, 0);
    chk("R1", "startupDone", startupDone, 0);
    chk("R1", "rcEn", rcEn, 1);
    chk("R1", "priOscEn", priOscEn, 0);
    chk("R1", "fastOscEn", fastOscEn, 0);
    rstN = 1'b1;
    step(2);
    chk("R1", "clkSel after reset", clkSel, 0);

    for (int pll = 0; pll < 2; pll++) begin
      for (int fv = 0; fv < (1 << FREQ_W); fv++) begin
        for (int is = 0; is < 2; is++) begin
          automatic int want = (fv != 0 || is != 0) ? 1 : 0;
          sysClkSel = (fv[0]) ? 2'b01 : 2'b10;
          freqSel = fv[FREQ_W-1:0]; intSrcSel = is[0];
          fastStable = 1'b0; usePll = pll[0]; pllLock = 1'b0;
          step(6);
          chk("R2_R3", "fastOscEn", fastOscEn, want);
          chk("R3", "clkSel before stable", clkSel, 0);
          chk("R3", "intStable before stable", intStable, 0);
          fastStable = 1'b1;
          step(6);
          chk("R2_R3", "intStable", intStable, want);
          chk("R2_R3", "clkSel", clkSel, want);
          sysClkSel = 2'b00;
          step(1);
          chk("R5", "priOscEn", priOscEn, 1);
          ticks(OST - 1);
          step(6);
          chk("R5", "clkSel one edge short", clkSel, want);
          chk("R4", "intStable while pending", intStable, want);
          chk("R8", "rcEn pending", rcEn, 1);
          ticks(1);
          if (pll != 0) begin
            step(PWAIT + 10);
            chk("R6", "clkSel without lock", clkSel, want);
            pllLock = 1'b1;
          end
          step(6);
          chk("R7", "clkSel primary", clkSel, 2);
          chk("R7", "startupDone", startupDone, 1);
          chk("R7", "intStable cleared", intStable, 0);
          chk("R7", "fastOscEn off", fastOscEn, 0);
          for (int w = 0; w < 4; w++) begin
            wdtEn = w[0]; fscmEn = w[1];
            step(2);
            chk("R8", "rcEn on primary", rcEn, (w != 0) ? 1 : 0);
          end
          wdtEn = 1'b0; fscmEn = 1'b0;
          sysClkSel = 2'b11;
          step(6);
          chk("R10", "startupDone cleared", startupDone, 0);
          chk("R10", "priOscEn off", priOscEn, 0);
          chk("R10", "clkSel back", clkSel, want);
        end
      end
    end

    // R6 timer dominates when lock is already present
    freqSel = 3'd2; intSrcSel = 1'b0; fastStable = 1'b1;
    usePll = 1'b1; pllLock = 1'b1; sysClkSel = 2'b10;
    step(6);
    sysClkSel = 2'b00; step(1);
    ticks(OST);
    step(PWAIT / 2);
    chk("R6", "clkSel before timer", clkSel, 1);
    step(PWAIT + 8);
    chk("R6", "clkSel after timer", clkSel, 2);

    // R9 withdrawn request, then restart from zero
    sysClkSel = 2'b10; usePll = 1'b0;
    step(8);
    sysClkSel = 2'b00; step(1);
    ticks(OST / 2);
    sysClkSel = 2'b10;
    step(4);
    chk("R9", "clkSel after withdraw", clkSel, 1);
    chk("R4", "intStable after withdraw", intStable, 1);
    sysClkSel = 2'b00; step(1);
    ticks(OST - 1);
    step(6);
    chk("R9", "count restarted", clkSel, 1);
    ticks(1); step(6);
    chk("R9", "switch after full count", clkSel, 2);

    // R9 PLL use changed while pending
    sysClkSel = 2'b10; step(8);
    sysClkSel = 2'b00; step(1);
    ticks(OST - 2);
    usePll = 1'b1; pllLock = 1'b1;
    ticks(OST - 1);
    step(6);
    chk("R9", "restart on PLL change", clkSel, 1);
    ticks(1);
    step(PWAIT + 8);
    chk("R9", "switch after restart", clkSel, 2);

    finish();
  end
endmodule